// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block translates a 48-bit guest virtual address into a system physical address when two page tables are stacked on top of each other. The guest table has four levels, and it lives in guest-physical memory. The nested table also has four levels, and it maps guest-physical addresses to system-physical ones. The guest table pointer and every guest page entry address are guest-physical, so the walker runs a full nested walk before it reads each guest entry. It runs one more nested walk on the final guest-physical data address. With 4 KB pages in both dimensions, a walk makes 24 entry reads.

A client pulses `start` with the guest address and the two root pointers. The walker issues one read at a time on a request/acknowledge memory port. It raises `done` for one cycle, and it then presents either the translated address and page size or a fault.

The controller has four states:

- `ST_IDLE`: waits for `start`.
- `ST_NEST`: reads a nested entry.
- `ST_GUEST`: reads a guest entry.
- `ST_DONE`: pulses `done`.

The transitions are:

- `ST_IDLE` goes to `ST_NEST` on `start`.
- `ST_NEST` steps down a level on each acknowledged non-leaf entry.
- `ST_NEST` goes to `ST_GUEST` on a leaf for a guest table.
- `ST_NEST` goes to `ST_DONE` on a leaf for the data address, or on a not-present entry.
- `ST_GUEST` goes back to `ST_NEST` on a present entry.
- `ST_GUEST` goes to `ST_DONE` on a not-present entry.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `tdw_walker`

## Requirements
- R1: While reset is low and right after it is released, `done`, `busy`, `mem_req` and `fault` are low.
- R2: A page entry has present in bit 0, page size in bit 7 and a 40-bit frame number in bits 51:12. An entry read at level L uses the address {table frame, index, 3'b000}, where index is address bits [12+9(L-1)+8 : 12+9(L-1)].
- R3: The walk order is as follows:
  1. A nested walk of the guest root.
  2. Guest level 4.
  3. A nested walk of the next guest table.
  4. The pattern repeats down to guest level 1.
  5. A nested walk of the data address.
  With 4 KB pages everywhere, this makes 24 reads and gives {frame, gva[11:0]}.
- R4: A present guest entry at level 2 with bit 7 set ends the guest dimension. The data address is then {frame[39:9], gva[20:0]}.
- R5: A present nested entry at level 2 with bit 7 set ends that nested walk. It gives {frame[39:9], gpa[20:0]}.
- R6: `big_page` is 1 (2 MB) only when both the guest and the final nested mapping are 2 MB. Otherwise the result is reported as 4 KB.
- R7: A not-present entry stops the walk with no further reads. `fault` is set, `fault_lvl` gives the level (1 to 4) and `fault_nested` is 1 for the nested dimension.
- R8: At most one read is outstanding. `mem_addr` holds while `mem_req` is high and `mem_ack` is low. A read completes in a cycle where both are high.
- R9: `done` is high for exactly one cycle. The result outputs hold until the next accepted `start`.
- R10: `start` is ignored while a walk is in progress. The result and the read count are those of the walk that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| gva | input | 48 | Guest virtual address |
| guest_root | input | 52 | Guest-physical base of the guest top table |
| nest_root | input | 52 | System-physical base of the nested top table |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 52 | System-physical address of the entry to read |
| mem_ack | input | 1 | Read accepted; data valid this cycle |
| mem_rdata | input | 64 | Page entry returned |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| spa | output | 52 | Translated system-physical address |
| big_page | output | 1 | 1 = 2 MB result, 0 = 4 KB |
| fault | output | 1 | Walk ended on a not-present entry |
| fault_lvl | output | 3 | Level of the faulting entry (1 to 4) |
| fault_nested | output | 1 | 1 = fault in nested dimension, 0 = guest |

## Verification
Two events can fall in the same cycle: a new `start` request, and an ongoing walk consuming a memory acknowledge. The bench starts a 4 KB walk and then pulses `start` with a different address a few cycles in, while reads are being acknowledged. The run is judged by two results. The returned address must belong to the first walk. The acknowledge count must stay at exactly 24 for that walk.

// File: rtl/tdw_pkg.sv
`timescale 1ns/1ps
package tdw_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 52;
    localparam int ENT_W  = 64;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 9;
    localparam int LEVELS = 4;
    localparam int LVL_W  = 3;
    localparam int FRM_W  = PA_W - OFF_W;
    localparam int BIG_W  = OFF_W + IDX_W;
    localparam int PS_BIT = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NEST,
        ST_GUEST,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/tdw_idx_pick.sv
`timescale 1ns/1ps
module tdw_idx_pick
    import tdw_pkg::*;
#(
    parameter int ADDR_W = VA_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LVL_W-1:0]  lvl,
    output logic [IDX_W-1:0]  idx
);
    localparam int TOP = OFF_W + IDX_W * LEVELS;

    logic [IDX_W-1:0] slice [LEVELS];
    logic [1:0]       sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = addr[OFF_W + IDX_W*g +: IDX_W];
    end

    assign sel = 2'(lvl - LVL_W'(1));
    assign idx = slice[sel];

    logic unused_bits;
    if (ADDR_W > TOP) begin : g_hi
        assign unused_bits = ^{addr[ADDR_W-1:TOP], addr[OFF_W-1:0]};
    end else begin : g_nohi
        assign unused_bits = ^addr[OFF_W-1:0];
    end
endmodule

// File: rtl/tdw_entry_dec.sv
`timescale 1ns/1ps
module tdw_entry_dec
    import tdw_pkg::*;
(
    input  logic [ENT_W-1:0] ent,
    output logic             present,
    output logic             size_bit,
    output logic [FRM_W-1:0] frame
);
    assign present  = ent[0];
    assign size_bit = ent[PS_BIT];
    assign frame    = ent[PA_W-1:OFF_W];

    logic unused_ent;
    assign unused_ent = ^{ent[ENT_W-1:PA_W], ent[OFF_W-1:PS_BIT+1], ent[PS_BIT-1:1]};
endmodule

// File: rtl/tdw_walker.sv
`timescale 1ns/1ps
module tdw_walker
    import tdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VA_W-1:0]  gva,
    input  logic [PA_W-1:0]  guest_root,
    input  logic [PA_W-1:0]  nest_root,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_ack,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [PA_W-1:0]  spa,
    output logic             big_page,
    output logic             fault,
    output logic [LVL_W-1:0] fault_lvl,
    output logic             fault_nested
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS);
    localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_TWO = LVL_W'(2);

    walk_st_e state_q, state_d;

    logic [VA_W-1:0]  gva_q;
    logic [PA_W-1:0]  nroot_q, gpa_q, tbl_q, gtbl_q;
    logic [LVL_W-1:0] nlvl_q, glvl_q;
    logic             last_q, gbig_q;
    logic [PA_W-1:0]  res_spa_q;
    logic             res_big_q, flt_q, flt_nst_q;
    logic [LVL_W-1:0] flt_lvl_q;

    logic             e_present, e_size;
    logic [FRM_W-1:0] e_frame;
    logic [IDX_W-1:0] n_idx, g_idx;
    logic             n_huge, n_leaf, g_huge;
    logic [PA_W-1:0]  leaf_pa;

    tdw_entry_dec u_dec (
        .ent      (mem_rdata),
        .present  (e_present),
        .size_bit (e_size),
        .frame    (e_frame)
    );

    tdw_idx_pick #(.ADDR_W(PA_W)) u_nidx (
        .addr (gpa_q),
        .lvl  (nlvl_q),
        .idx  (n_idx)
    );

    tdw_idx_pick #(.ADDR_W(VA_W)) u_gidx (
        .addr (gva_q),
        .lvl  (glvl_q),
        .idx  (g_idx)
    );

    assign n_huge  = (nlvl_q == LVL_TWO) && e_size;
    assign n_leaf  = (nlvl_q == LVL_ONE) || n_huge;
    assign g_huge  = (glvl_q == LVL_TWO) && e_size;
    assign leaf_pa = n_huge ? {e_frame[FRM_W-1:IDX_W], gpa_q[BIG_W-1:0]}
                            : {e_frame, gpa_q[OFF_W-1:0]};

    logic unused_roots;
    assign unused_roots = ^{guest_root[OFF_W-1:0], nest_root[OFF_W-1:0],
                            tbl_q[OFF_W-1:0], gtbl_q[OFF_W-1:0]};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_NEST;
            ST_NEST:  if (mem_ack) begin
                          if (!e_present)  state_d = ST_DONE;
                          else if (n_leaf) state_d = last_q ? ST_DONE : ST_GUEST;
                      end
            ST_GUEST: if (mem_ack) state_d = e_present ? ST_NEST : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gva_q <= '0; nroot_q <= '0; gpa_q <= '0; tbl_q <= '0; gtbl_q <= '0;
            nlvl_q <= TOP_LVL; glvl_q <= TOP_LVL; last_q <= 1'b0; gbig_q <= 1'b0;
            res_spa_q <= '0; res_big_q <= 1'b0;
            flt_q <= 1'b0; flt_lvl_q <= '0; flt_nst_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    gva_q     <= gva;
                    nroot_q   <= {nest_root[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                    tbl_q     <= {nest_root[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                    gpa_q     <= {guest_root[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                    nlvl_q    <= TOP_LVL;
                    glvl_q    <= TOP_LVL;
                    last_q    <= 1'b0;
                    gbig_q    <= 1'b0;
                    res_spa_q <= '0;
                    res_big_q <= 1'b0;
                    flt_q     <= 1'b0;
                    flt_lvl_q <= '0;
                    flt_nst_q <= 1'b0;
                end
                ST_NEST: if (mem_ack) begin
                    if (!e_present) begin
                        flt_q     <= 1'b1;
                        flt_lvl_q <= nlvl_q;
                        flt_nst_q <= 1'b1;
                    end else if (n_leaf) begin
                        if (last_q) begin
                            res_spa_q <= leaf_pa;
                            res_big_q <= gbig_q && n_huge;
                        end else begin
                            gtbl_q <= leaf_pa;
                        end
                    end else begin
                        tbl_q  <= {e_frame, {OFF_W{1'b0}}};
                        nlvl_q <= nlvl_q - LVL_ONE;
                    end
                end
                ST_GUEST: if (mem_ack) begin
                    if (!e_present) begin
                        flt_q     <= 1'b1;
                        flt_lvl_q <= glvl_q;
                        flt_nst_q <= 1'b0;
                    end else begin
                        tbl_q  <= nroot_q;
                        nlvl_q <= TOP_LVL;
                        if (g_huge) begin
                            gpa_q  <= {e_frame[FRM_W-1:IDX_W], gva_q[BIG_W-1:0]};
                            gbig_q <= 1'b1;
                            last_q <= 1'b1;
                        end else if (glvl_q == LVL_ONE) begin
                            gpa_q  <= {e_frame, gva_q[OFF_W-1:0]};
                            last_q <= 1'b1;
                        end else begin
                            gpa_q  <= {e_frame, {OFF_W{1'b0}}};
                            glvl_q <= glvl_q - LVL_ONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req      = (state_q == ST_NEST) || (state_q == ST_GUEST);
        mem_addr     = (state_q == ST_GUEST) ? {gtbl_q[PA_W-1:OFF_W], g_idx, 3'b000}
                                             : {tbl_q[PA_W-1:OFF_W],  n_idx, 3'b000};
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_DONE);
        spa          = res_spa_q;
        big_page     = res_big_q;
        fault        = flt_q;
        fault_lvl    = flt_lvl_q;
        fault_nested = flt_nst_q;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R7
    AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> (fault_lvl >= LVL_ONE) && (fault_lvl <= TOP_LVL)); // R7
    AST_BIG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done && big_page |-> !fault); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(gva_q)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(spa) && $stable(fault) && $stable(big_page)); // R9
endmodule

// File: tb/tdw_walker_bench.sv
`timescale 1ns/1ps
module tdw_walker_bench;
    import tdw_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n, start, mem_req, mem_ack, busy, done, big_page, fault, fault_nested;
    logic [VA_W-1:0]  gva;
    logic [PA_W-1:0]  guest_root, nest_root, mem_addr, spa;
    logic [ENT_W-1:0] mem_rdata;
    logic [LVL_W-1:0] fault_lvl;

    tdw_walker u_tdw_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .gva(gva),
        .guest_root(guest_root), .nest_root(nest_root),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .spa(spa), .big_page(big_page),
        .fault(fault), .fault_lvl(fault_lvl), .fault_nested(fault_nested)
    );

    localparam logic [51:0] N_ROOT = 52'h0010_0000;
    localparam logic [51:0] G_ROOT = 52'h0020_0000;
    localparam logic [51:0] G_OFF  = 52'h4000_0000;
    localparam int NROW = 7;

    localparam logic [47:0] T_GVA  [NROW] = '{48'h0000_0040_3ABC, 48'h0000_8061_2345,
        48'h0001_00A3_4567, 48'h0002_0000_5DEF, 48'h0000_0040_4000, 48'h0003_0000_0111, 48'h8000_0000_0000};
    localparam logic [51:0] T_GPA  [NROW] = '{52'h0300_5000, 52'h0400_0000, 52'h0600_0000,
        52'h0800_0000, 52'h0, 52'h80_0000_0000, 52'h0};
    localparam bit          T_GBIG [NROW] = '{0, 1, 1, 0, 0, 0, 0};
    localparam bit          T_DOG  [NROW] = '{1, 1, 1, 1, 0, 1, 0};
    localparam logic [51:0] T_NPG  [NROW] = '{52'h0300_5000, 52'h0400_0000, 52'h0603_4000,
        52'h0800_0000, 52'h0, 52'h0, 52'h0};
    localparam logic [51:0] T_SPG  [NROW] = '{52'h7_7700_3000, 52'h9_0060_0000, 52'h5_1234_5000,
        52'hA_0020_0000, 52'h0, 52'h0, 52'h0};
    localparam bit          T_NBIG [NROW] = '{0, 1, 0, 1, 0, 0, 0};
    localparam bit          T_DON  [NROW] = '{1, 1, 1, 1, 0, 0, 0};
    localparam logic [51:0] T_ESPA [NROW] = '{52'h7_7700_3ABC, 52'h9_0061_2345, 52'h5_1234_5567,
        52'hA_0020_0DEF, 52'h0, 52'h0, 52'h0};
    localparam bit          T_EBIG [NROW] = '{0, 1, 0, 0, 0, 0, 0};
    localparam bit          T_EFLT [NROW] = '{0, 0, 0, 0, 1, 1, 1};
    localparam int          T_ELVL [NROW] = '{0, 0, 0, 0, 1, 4, 4};
    localparam bit          T_ENST [NROW] = '{0, 0, 0, 0, 0, 1, 0};
    localparam int          T_EREF [NROW] = '{24, 18, 19, 23, 20, 21, 5};

    logic [63:0] pmem [logic [51:0]];
    logic [51:0] nalloc = 52'h0010_1000;
    logic [51:0] galloc = 52'h0020_1000;
    int unsigned lat = 0, wcnt = 0, refs = 0;
    int checks = 0, fails = 0;
    bit ended = 0;

    // memory model: answers after lat idle cycles, one read at a time
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   = 1'b1;
                mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 64'h0;
                wcnt      = 0;
                refs++;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt    = 0;
        end
    end

    function automatic logic [63:0] mk(input logic [51:0] pa, input bit big);
        return {12'h0, pa[51:12], 4'h0, big, 6'h0, 1'b1};
    endfunction

    function automatic logic [51:0] ix8(input logic [51:0] a, input int l);
        return 52'(((a >> (12 + 9*(l-1))) & 52'h1FF) * 8);
    endfunction

    task automatic nmap(input logic [51:0] g, input logic [51:0] s, input bit big);
        logic [51:0] t = N_ROOT;
        logic [51:0] a;
        int stop = big ? 2 : 1;
        for (int l = 4; l > stop; l--) begin
            a = t + ix8(g, l);
            if (!pmem.exists(a)) begin pmem[a] = mk(nalloc, 0); nalloc += 52'h1000; end
            t = {pmem[a][51:12], 12'h0};
        end
        pmem[t + ix8(g, stop)] = mk(s, big);
    endtask

    task automatic gmap(input logic [51:0] v, input logic [51:0] g, input bit big);
        logic [51:0] t = G_ROOT;
        logic [51:0] a;
        int stop = big ? 2 : 1;
        for (int l = 4; l > stop; l--) begin
            a = t + G_OFF + ix8(v, l);
            if (!pmem.exists(a)) begin
                nmap(galloc, galloc + G_OFF, 0);
                pmem[a] = mk(galloc, 0);
                galloc += 52'h1000;
            end
            t = {pmem[a][51:12], 12'h0};
        end
        pmem[t + G_OFF + ix8(v, stop)] = mk(g, big);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // launches a walk, optionally re-pulses start mid-walk, returns refs used
    task automatic walk(input logic [47:0] v, input int inj_at, input logic [47:0] inj_v,
                        output int used, output bit got);
        int r0 = refs;
        int n = 0;
        @(negedge clk); gva = v; start = 1'b1;
        @(negedge clk); start = 1'b0;
        got = 0;
        while (n < 400 && !got) begin
            if (n == inj_at) begin gva = inj_v; start = 1'b1; end
            else start = 1'b0;
            if (done) got = 1;
            else begin @(negedge clk); n++; end
        end
        start = 1'b0;
        used = refs - r0;
    endtask

    initial begin
        int used;
        bit got;
        logic [51:0] keep;
        rst_n = 1'b0; start = 1'b0; gva = '0;
        guest_root = G_ROOT; nest_root = N_ROOT;
        mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_req && !fault, "R1", "outputs in reset",
            {done, busy, mem_req, fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mem_req && !fault, "R1", "outputs after reset",
            {done, busy, mem_req, fault}, 0);

        nmap(G_ROOT, G_ROOT + G_OFF, 0);
        for (int i = 0; i < NROW; i++) begin
            if (T_DOG[i]) gmap(T_GVA[i], T_GPA[i], T_GBIG[i]);
            if (T_DON[i]) nmap(T_NPG[i], T_SPG[i], T_NBIG[i]);
        end

        // row order: R2 R3 4K/4K, R4 R6 guest 2M nested 2M, R6 guest 2M nested 4K,
        // R5 guest 4K nested 2M, R7 guest L1 absent, R7 nested L4 absent, R7 guest L4 absent
        for (int i = 0; i < NROW; i++) begin
            lat = i % 3;
            walk(T_GVA[i], -1, '0, used, got);
            chk(got, "R9", $sformatf("row %0d done seen", i), got, 1);
            chk(spa == T_ESPA[i], (i == 0) ? "R2 R3" : (i < 4) ? "R4 R5" : "R7",
                $sformatf("row %0d spa", i), spa, T_ESPA[i]);
            chk(big_page == T_EBIG[i], "R6", $sformatf("row %0d size", i), big_page, T_EBIG[i]);
            chk(fault == T_EFLT[i] && fault_nested == T_ENST[i] && int'(fault_lvl) == T_ELVL[i],
                "R7", $sformatf("row %0d fault/dim/lvl", i),
                {fault, fault_nested, fault_lvl}, {T_EFLT[i], T_ENST[i], 3'(T_ELVL[i])});
            chk(used == T_EREF[i], "R3", $sformatf("row %0d read count", i), used, T_EREF[i]);
            @(negedge clk);
            chk(!done && spa == T_ESPA[i], "R9", $sformatf("row %0d pulse/hold", i),
                {done, spa}, {1'b0, T_ESPA[i]});
        end

        // R10: start mid-walk while reads are being acknowledged
        lat = 0;
        walk(T_GVA[0], 3, T_GVA[1], used, got);
        chk(spa == T_ESPA[0], "R10", "mid-walk start result", spa, T_ESPA[0]);
        chk(used == 24, "R10", "mid-walk start read count", used, 24);

        // R9 R8: result held over idle cycles with a slow memory
        lat = 2;
        walk(T_GVA[3], -1, '0, used, got);
        keep = spa;
        repeat (4) @(negedge clk);
        chk(spa == keep && spa == T_ESPA[3] && !busy && !mem_req, "R9 R8", "idle hold",
            spa, T_ESPA[3]);
        chk(used == 23, "R8", "slow memory read count", used, 23);
        finish_run();
    end

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end
endmodule